// File: doc/BRIEF.md
# Serial Cyclic Hamming Syndrome Decoder

This block takes a cyclic Hamming (15,11) codeword one bit per clock and rebuilds it in a shift register. While the bits arrive, a polynomial-division shift register forms the 4-bit remainder of the received word modulo the generator g(x) = x^4 + x + 1. After the last bit, a nonzero remainder raises an error flag. The flag enables a table indexed by the remainder, and the table gives a one-hot mask that flips the wrong bit back. Any one flipped bit is fixed, whether it lies in the message field or in the check field.

The codeword is systematic. The 11 message bits sit at positions 14 down to 4, and the 4 check bits at positions 3 down to 0. Position i stands for the coefficient of x^i. A small controller has three named states. ST_IDLE waits for the first bit; an accepted bit there loads the registers fresh and moves to ST_COLLECT. ST_COLLECT shifts in bits; accepting bit number N_BITS moves it to ST_REPORT. ST_REPORT presents the result for one cycle and always returns to ST_IDLE. A shortened code with fewer bits and the same generator is built by lowering N_BITS and K_BITS together.

Top module: `hsd_decoder`

## Requirements
- R1: After reset, dec_valid is low and the controller waits in ST_IDLE for the first bit of a new word.
- R2: A code bit is taken from in_bit on each rising edge where in_valid is high. Position 14 arrives first and position 0 last. Cycles with in_valid low add no bit and lose none of the bits already taken.
- R3: dec_valid is high in the cycle after the edge that takes the 15th bit, and it stays high for exactly one cycle.
- R4: While dec_valid is high, dec_syn equals the received word modulo x^4 + x + 1. Bit j of dec_syn is the coefficient of x^j.
- R5: While dec_valid is high, dec_err is high exactly when dec_syn is nonzero.
- R6: With zero errors, or with one flipped bit at any of the 15 positions, dec_word equals the transmitted codeword while dec_valid is high.
- R7: dec_msg equals dec_word[14:4]. A transmitted word carries the message m in [14:4] and (m·x^4 mod g) in [3:0].
- R8: dec_par_fix is high while dec_valid is high exactly when the corrected bit lies in [3:0]. In that case the message field needed no change.
- R9: An in_valid pulse during the ST_REPORT cycle is ignored. The next word starts cleanly at the next accepted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when in_bit holds a code bit |
| in_bit | input | 1 | Serial code bit, highest position first |
| dec_valid | output | 1 | One-cycle pulse: result fields are valid |
| dec_word | output | 15 | Corrected codeword |
| dec_msg | output | 11 | Corrected message, dec_word[14:4] |
| dec_syn | output | 4 | Remainder of the received word modulo g(x) |
| dec_err | output | 1 | Remainder is nonzero |
| dec_par_fix | output | 1 | The corrected bit lies in the check field |

## Verification
The bench builds the block with its default (15,11) parameters. At this size the full set of 2048 messages can be swept. Each message is paired with an error position that cycles through all 15 positions plus the error-free case, so every table entry is used many times. One message is also run through all 16 cases in a row. Across the sweep, stall cycles in the middle of a word and input pulses during the report cycle put the ignored-input and gap rules to the test.

// File: rtl/hsd_pkg.sv
`timescale 1ns/1ps
package hsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REPORT  = 2'd2
    } hsd_state_t;

endpackage

// File: rtl/hsd_divider.sv
`timescale 1ns/1ps
// Remainder register: each accepted bit computes rem = (rem*x + bit) mod g.
module hsd_divider #(
    parameter int          M_BITS  = 4,
    parameter logic [3:0]  GEN_LOW = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              restart,
    input  logic              bit_in,
    output logic [M_BITS-1:0] rem
);
    logic [M_BITS-1:0] base;
    logic [M_BITS-1:0] rem_next;
    logic [M_BITS-1:0] gen_tap;

    assign gen_tap = GEN_LOW[M_BITS-1:0];

    always_comb begin
        base     = restart ? '0 : rem;
        rem_next = {base[M_BITS-2:0], bit_in};
        if (base[M_BITS-1]) begin
            rem_next = rem_next ^ gen_tap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (shift_en) begin
            rem <= rem_next;
        end
    end
endmodule

// File: rtl/hsd_lookup.sv
`timescale 1ns/1ps
// Maps a remainder to a one-hot flip mask. Entry i holds x^i mod g.
module hsd_lookup #(
    parameter int         N_BITS  = 15,
    parameter int         M_BITS  = 4,
    parameter logic [3:0] GEN_LOW = 4'b0011
) (
    input  logic              enable,
    input  logic [M_BITS-1:0] syn,
    output logic [N_BITS-1:0] mask
);
    function automatic logic [M_BITS-1:0] pos_syn(input int pos);
        logic [M_BITS-1:0] r;
        r = M_BITS'(1);
        for (int k = 0; k < pos; k++) begin
            if (r[M_BITS-1]) begin
                r = {r[M_BITS-2:0], 1'b0} ^ GEN_LOW[M_BITS-1:0];
            end else begin
                r = {r[M_BITS-2:0], 1'b0};
            end
        end
        return r;
    endfunction

    for (genvar i = 0; i < N_BITS; i++) begin : g_pos
        localparam logic [M_BITS-1:0] SYN_I = pos_syn(i);
        assign mask[i] = enable && (syn == SYN_I);
    end
endmodule

// File: rtl/hsd_ctrl.sv
`timescale 1ns/1ps
module hsd_ctrl
    import hsd_pkg::*;
#(
    parameter int N_BITS = 15,
    localparam int CW    = $clog2(N_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          accept,
    output logic          restart,
    output logic          report,
    output logic [CW-1:0] bit_cnt
);
    localparam logic [CW-1:0] LAST = CW'(N_BITS - 1);

    hsd_state_t state_q;
    hsd_state_t state_d;
    logic [CW-1:0] cnt_d;

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = bit_cnt;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_COLLECT;
                    cnt_d   = CW'(1);
                end
            end
            ST_COLLECT: begin
                if (in_valid) begin
                    if (bit_cnt == LAST) begin
                        state_d = ST_REPORT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = bit_cnt + CW'(1);
                    end
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state_q <= state_d;
            bit_cnt <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        accept  = 1'b0;
        restart = 1'b0;
        report  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept  = in_valid;
                restart = 1'b1;
            end
            ST_COLLECT: accept = in_valid;
            ST_REPORT:  report = 1'b1;
            default:    report = 1'b0;
        endcase
    end
endmodule

// File: rtl/hsd_decoder.sv
`timescale 1ns/1ps
module hsd_decoder #(
    parameter int         N_BITS  = 15,
    parameter int         K_BITS  = 11,
    parameter logic [3:0] GEN_LOW = 4'b0011,
    localparam int        M_BITS  = N_BITS - K_BITS,
    localparam int        CW      = $clog2(N_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic              dec_valid,
    output logic [N_BITS-1:0] dec_word,
    output logic [K_BITS-1:0] dec_msg,
    output logic [M_BITS-1:0] dec_syn,
    output logic              dec_err,
    output logic              dec_par_fix
);
    logic              accept;
    logic              restart;
    logic              report;
    logic [CW-1:0]     bit_cnt;
    logic [N_BITS-1:0] rx_word;
    logic [M_BITS-1:0] syn;
    logic              syn_nz;
    logic [N_BITS-1:0] fix_mask;
    logic [N_BITS-1:0] fixed_word;

    hsd_ctrl #(.N_BITS(N_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .accept   (accept),
        .restart  (restart),
        .report   (report),
        .bit_cnt  (bit_cnt)
    );

    hsd_divider #(.M_BITS(M_BITS), .GEN_LOW(GEN_LOW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .restart  (restart),
        .bit_in   (in_bit),
        .rem      (syn)
    );

    // Received word, first bit ends at the top position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (accept) begin
            if (restart) begin
                rx_word <= {{(N_BITS-1){1'b0}}, in_bit};
            end else begin
                rx_word <= {rx_word[N_BITS-2:0], in_bit};
            end
        end
    end

    assign syn_nz = |syn;

    hsd_lookup #(.N_BITS(N_BITS), .M_BITS(M_BITS), .GEN_LOW(GEN_LOW)) u_lut (
        .enable (syn_nz),
        .syn    (syn),
        .mask   (fix_mask)
    );

    assign fixed_word  = rx_word ^ fix_mask;
    assign dec_valid   = report;
    assign dec_word    = fixed_word;
    assign dec_msg     = fixed_word[N_BITS-1:M_BITS];
    assign dec_syn     = syn;
    assign dec_err     = syn_nz;
    assign dec_par_fix = |fix_mask[M_BITS-1:0];
endmodule

// File: rtl/hsd_decoder_chk.sv
`timescale 1ns/1ps
module hsd_decoder_chk #(
    parameter int N_BITS = 15,
    parameter int K_BITS = 11,
    localparam int M_BITS = N_BITS - K_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              dec_valid,
    input logic [K_BITS-1:0] dec_msg,
    input logic              dec_err,
    input logic              dec_par_fix,
    input logic [N_BITS-1:0] fix_mask,
    input logic [N_BITS-1:0] rx_word
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    a_r3_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid));

    a_r5_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_err) |-> $onehot(fix_mask));

    a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_err) |-> (fix_mask == '0));

    a_r8_parity_keeps_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_par_fix) |-> (dec_msg == rx_word[N_BITS-1:M_BITS]));

    a_r9_report_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> $stable(rx_word));
endmodule

bind hsd_decoder hsd_decoder_chk #(.N_BITS(N_BITS), .K_BITS(K_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .dec_valid   (dec_valid),
    .dec_msg     (dec_msg),
    .dec_err     (dec_err),
    .dec_par_fix (dec_par_fix),
    .fix_mask    (fix_mask),
    .rx_word     (rx_word)
);

// File: tb/hsd_decoder_bench.sv
`timescale 1ns/1ps
module hsd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        dec_valid;
    logic [14:0] dec_word;
    logic [10:0] dec_msg;
    logic [3:0]  dec_syn;
    logic        dec_err;
    logic        dec_par_fix;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hsd_decoder u_hsd_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .dec_valid   (dec_valid),
        .dec_word    (dec_word),
        .dec_msg     (dec_msg),
        .dec_syn     (dec_syn),
        .dec_err     (dec_err),
        .dec_par_fix (dec_par_fix)
    );

    // Long division of a 15-bit polynomial by x^4+x+1
    function automatic logic [3:0] poly_mod(input logic [14:0] v);
        logic [14:0] t;
        t = v;
        for (int b = 14; b >= 4; b--) begin
            if (t[b]) t = t ^ (15'b10011 << (b - 4));
        end
        return t[3:0];
    endfunction

    function automatic logic [14:0] encode(input logic [10:0] m);
        logic [14:0] sh;
        sh = {m, 4'b0000};
        return sh | {11'b0, poly_mod(sh)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send a word, optional stall before bit index gap (-1 for none),
    // optional junk pulse during the report cycle; then check results.
    task automatic run_word(input logic [10:0] m, input int epos, input int gap, input bit junk);
        logic [14:0] cw;
        logic [14:0] rx;
        logic [3:0]  esyn;
        cw = encode(m);
        rx = cw;
        if (epos < 15) rx[epos] = ~rx[epos];
        esyn = poly_mod(rx);
        for (int i = 0; i < 15; i++) begin
            if (i == gap) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_bit   = 1'b1;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = rx[14 - i];
        end
        @(negedge clk);
        in_valid = junk;
        in_bit   = 1'b1;
        chk(dec_valid == 1'b1, "R3 valid", int'(dec_valid), 1);
        chk(dec_syn == esyn, "R4 syndrome", int'(dec_syn), int'(esyn));
        chk(dec_err == (esyn != 4'd0), "R5 error flag", int'(dec_err), int'(esyn != 4'd0));
        chk(dec_word == cw, "R6 corrected word", int'(dec_word), int'(cw));
        chk(dec_msg == m, "R7 message", int'(dec_msg), int'(m));
        chk(dec_par_fix == (epos < 4), "R8 parity fix", int'(dec_par_fix), int'(epos < 4));
        @(negedge clk);
        in_valid = 1'b0;
        chk(dec_valid == 1'b0, "R3 single pulse", int'(dec_valid), 0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dec_valid == 1'b0, "R1 reset valid", int'(dec_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R1 idle valid", int'(dec_valid), 0);

        // R6: one message through every error position plus none
        for (int e = 0; e < 16; e++) begin
            run_word(11'h5A3, e, -1, 1'b0);
        end

        // R2/R9: full message sweep with stalls and report-cycle pulses
        for (int m = 0; m < 2048; m++) begin
            run_word(11'(m), m % 16, (m % 7 == 0) ? (m % 15) : -1, (m % 5 == 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule